// File: doc/BRIEF.md
# Trace Sink Control Register File

This block is the software-visible control point of a trace pin sink. A simple word-wide bus with a write strobe, a byte address and a combinational read port reaches two 32-bit registers. The control register at byte offset 0x000 holds the power request, the output enable, a read-only drain-empty flag, the pin protocol mode, a clock-centering option, a calibration option, an alignment-sync spacing field and a 16-bit clock divider. The identification register at byte offset 0x004 is read-only. The block decodes these fields and drives them straight out to the transmit datapath.

The mode field accepts only the protocol codes the sink supports, and any other value written to it is dropped. Clock centering can only be turned on when the resulting mode is a parallel one. A write to the power request bit does not change the value read back at once. An internal counter models a power transition of fixed length, and bit 0 follows the request only after that transition ends. While the sink is powered down, the field registers keep their contents but cannot be written, and everything the bus reads apart from the power state and the empty flag is zero.

Top module: `trace_sink_regs`

## Requirements
- R1: After reset, the control register reads 0x00000008: power state 0, enable 0, empty flag 1, and every other field 0. The divider output is 0x000F. All other outputs are 0.
- R2: A write of bit 0 to offset 0x000 sets the power request. Bit 0 of the control register and `active_o` take the requested value exactly PWR_LAT clock cycles after the write edge, and not before. PWR_LAT defaults to 4.
- R3: While the power state is 0, the following hold. Writes to every control field except bit 0 are ignored. The control register reads as {31'b0 except bit 3 = 1, bit 0 = power state}. Offset 0x004 reads 0. A write that lands on the same edge at which power-up completes is also ignored.
- R4: The mode field is bits 7:4. It takes a written value only if that value is 0 (off), 4 (Manchester serial), 5 (UART serial) or 8 to 12 (parallel). Any other value leaves the field unchanged.
- R5: Clock-center is bit 8. It stores 1 only when the written bit is 1 and the mode that results from the same write is 8 to 12. In every other case it stores 0, so a move to a non-parallel mode clears it.
- R6: The control register layout is as follows. Bit 1 is enable. Bit 9 is calibrate. Bits 14:12 are the sync spacing. Bits 31:16 are the divider. Bits 2, 10, 11 and 15 always read 0.
- R7: While powered, offset 0x004 reads 0x00000A01: major version 1 in bits 3:0, minor version 0 in bits 7:4, component type 0xA in bits 11:8.
- R8: The following outputs always equal the stored fields, also while powered down: `mode_o`, `clk_center_o`, `calibrate_o`, `sync_freq_o` and `divider_o`. `enable_o` equals the stored enable bit ANDed with the power state.
- R9: While powered, control bit 3 equals the `drain_empty` input.
- R10: A read of any address other than 0x000 or 0x004 returns 0. A write to such an address changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, sampled on the rising edge |
| addr | input | ADDR_W (12) | Byte address for reads and writes |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| drain_empty | input | 1 | Datapath reports its buffers are empty |
| active_o | output | 1 | Completed power state |
| enable_o | output | 1 | Output enable, gated by power state |
| mode_o | output | 4 | Pin protocol mode code |
| clk_center_o | output | 1 | Centered trace clock in parallel modes |
| calibrate_o | output | 1 | Calibration pattern request |
| sync_freq_o | output | 3 | Alignment-sync spacing |
| divider_o | output | 16 | Clock divider value |

## Verification
Two functions can fall in the same cycle. The first is completion of a power-up. The second is a write to the control fields, which is only honoured once the power state is 1. The bench provokes this by issuing the field write exactly PWR_LAT-1 idle cycles after the power request, so the write edge is the completion edge. The bench then judges that bit 0 reads 1 while every field still holds its reset value. A second overlap is a single write that changes the mode and sets clock-center together; it is judged against the mode that results from that same write.

// File: rtl/trace_sink_pkg.sv
package trace_sink_pkg;

    localparam int unsigned DATA_W = 32;
    localparam int unsigned DIV_W  = 16;

    // byte offsets of the two registers
    localparam logic [11:0] CTRL_OFS = 12'h000;
    localparam logic [11:0] IMPL_OFS = 12'h004;

    // identification value fields
    localparam logic [3:0] ID_MAJOR = 4'd1;
    localparam logic [3:0] ID_MINOR = 4'd0;
    localparam logic [3:0] ID_KIND  = 4'hA;

    typedef enum logic [3:0] {
        SM_OFF    = 4'd0,
        SM_MANCH  = 4'd4,
        SM_UART   = 4'd5,
        SM_PAR_1  = 4'd8,
        SM_PAR_2  = 4'd9,
        SM_PAR_4  = 4'd10,
        SM_PAR_8  = 4'd11,
        SM_PAR_16 = 4'd12
    } sink_mode_e;

    typedef struct packed {
        logic             enable;
        sink_mode_e       mode;
        logic             clk_center;
        logic             calibrate;
        logic [2:0]       sync_freq;
        logic [DIV_W-1:0] divider;
    } ctrl_fields_t;

    function automatic logic mode_legal(input logic [3:0] code);
        return (code == 4'd0) || (code == 4'd4) || (code == 4'd5) ||
               ((code >= 4'd8) && (code <= 4'd12));
    endfunction

    function automatic logic mode_parallel(input logic [3:0] code);
        return (code >= 4'd8) && (code <= 4'd12);
    endfunction

    function automatic logic [DATA_W-1:0] pack_ctrl(input ctrl_fields_t f,
                                                    input logic powered,
                                                    input logic empty);
        logic [DATA_W-1:0] w;
        w          = '0;
        w[0]       = powered;
        w[3]       = empty;
        if (powered) begin
            w[1]     = f.enable;
            w[7:4]   = f.mode;
            w[8]     = f.clk_center;
            w[9]     = f.calibrate;
            w[14:12] = f.sync_freq;
            w[31:16] = f.divider;
        end
        return w;
    endfunction

endpackage

// File: rtl/trace_sink_warl.sv
module trace_sink_warl
    import trace_sink_pkg::*;
(
    input  ctrl_fields_t            cur,
    input  logic [DATA_W-1:0]       wdata,
    output ctrl_fields_t            nxt
);
    logic [3:0] new_mode;
    logic       unused_wbits;

    assign unused_wbits = ^{wdata[3:2], wdata[11:10], wdata[15], wdata[0]};

    always_comb begin
        new_mode = mode_legal(wdata[7:4]) ? wdata[7:4] : cur.mode;
        nxt            = cur;
        nxt.enable     = wdata[1];
        nxt.mode       = sink_mode_e'(new_mode);
        nxt.clk_center = wdata[8] & mode_parallel(new_mode);
        nxt.calibrate  = wdata[9];
        nxt.sync_freq  = wdata[14:12];
        nxt.divider    = wdata[31:16];
    end
endmodule

// File: rtl/trace_sink_pwr.sv
module trace_sink_pwr #(
    parameter int unsigned PWR_LAT = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic req,
    output logic on
);
    localparam int unsigned CNT_W = (PWR_LAT < 2) ? 1 : $clog2(PWR_LAT);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PWR_LAT - 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            on  <= 1'b0;
            cnt <= '0;
        end else if (req != on) begin
            if (cnt == LAST) begin
                on  <= req;
                cnt <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end else begin
            cnt <= '0;
        end
    end
endmodule

// File: rtl/trace_sink_regs.sv
module trace_sink_regs
    import trace_sink_pkg::*;
#(
    parameter int unsigned ADDR_W    = 12,
    parameter int unsigned PWR_LAT   = 4,
    parameter logic [15:0] DIV_RESET = 16'h000F
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    input  logic              drain_empty,
    output logic              active_o,
    output logic              enable_o,
    output logic [3:0]        mode_o,
    output logic              clk_center_o,
    output logic              calibrate_o,
    output logic [2:0]        sync_freq_o,
    output logic [15:0]       divider_o
);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_OFS);
    localparam logic [ADDR_W-1:0] A_IMPL = ADDR_W'(IMPL_OFS);
    localparam ctrl_fields_t FIELDS_RST = '{
        enable: 1'b0, mode: SM_OFF, clk_center: 1'b0, calibrate: 1'b0,
        sync_freq: 3'd0, divider: DIV_RESET};

    ctrl_fields_t fields_q, fields_nxt;
    logic         pwr_req_q;
    logic         pwr_on;
    logic         wr_ctrl;

    assign wr_ctrl = wr_en && (addr == A_CTRL);

    always_ff @(posedge clk) begin
        if (rst) begin
            pwr_req_q <= 1'b0;
        end else if (wr_ctrl) begin
            pwr_req_q <= wdata[0];
        end
    end

    trace_sink_pwr #(.PWR_LAT(PWR_LAT)) u_pwr (
        .clk (clk),
        .rst (rst),
        .req (pwr_req_q),
        .on  (pwr_on)
    );

    trace_sink_warl u_warl (
        .cur   (fields_q),
        .wdata (wdata),
        .nxt   (fields_nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            fields_q <= FIELDS_RST;
        end else if (wr_ctrl && pwr_on) begin
            fields_q <= fields_nxt;
        end
    end

    always_comb begin
        rdata = '0;
        if (addr == A_CTRL) begin
            rdata = pack_ctrl(fields_q, pwr_on, pwr_on ? drain_empty : 1'b1);
        end else if ((addr == A_IMPL) && pwr_on) begin
            rdata[3:0]  = ID_MAJOR;
            rdata[7:4]  = ID_MINOR;
            rdata[11:8] = ID_KIND;
        end
    end

    assign active_o     = pwr_on;
    assign enable_o     = fields_q.enable & pwr_on;
    assign mode_o       = fields_q.mode;
    assign clk_center_o = fields_q.clk_center;
    assign calibrate_o  = fields_q.calibrate;
    assign sync_freq_o  = fields_q.sync_freq;
    assign divider_o    = fields_q.divider;
endmodule

// File: rtl/trace_sink_regs_chk.sv
module trace_sink_regs_chk #(
    parameter int unsigned ADDR_W = 12
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [31:0]       rdata,
    input logic              active_o,
    input logic              enable_o,
    input logic [3:0]        mode_o,
    input logic              clk_center_o,
    input logic              calibrate_o,
    input logic [2:0]        sync_freq_o,
    input logic [15:0]       divider_o
);
    // R4
    mode_legal_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_o == 4'd0) || (mode_o == 4'd4) || (mode_o == 4'd5) ||
        ((mode_o >= 4'd8) && (mode_o <= 4'd12)));

    // R5
    center_parallel_chk: assert property (@(posedge clk) disable iff (rst)
        clk_center_o |-> ((mode_o >= 4'd8) && (mode_o <= 4'd12)));

    // R3
    off_write_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (addr == '0) && !active_o) |=>
            ($stable(mode_o) && $stable(clk_center_o) && $stable(calibrate_o) &&
             $stable(sync_freq_o) && $stable(divider_o)));

    // R8
    enable_gated_chk: assert property (@(posedge clk) disable iff (rst)
        !active_o |-> !enable_o);

    // R10
    unmapped_read_chk: assert property (@(posedge clk) disable iff (rst)
        ((addr != ADDR_W'(0)) && (addr != ADDR_W'(4))) |-> (rdata == 32'd0));

    // R6
    reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (addr == '0) |-> ((rdata[2] == 1'b0) && (rdata[11:10] == 2'b00) &&
                          (rdata[15] == 1'b0)));
endmodule

bind trace_sink_regs trace_sink_regs_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .wr_en        (wr_en),
    .addr         (addr),
    .rdata        (rdata),
    .active_o     (active_o),
    .enable_o     (enable_o),
    .mode_o       (mode_o),
    .clk_center_o (clk_center_o),
    .calibrate_o  (calibrate_o),
    .sync_freq_o  (sync_freq_o),
    .divider_o    (divider_o)
);

// File: tb/tb_trace_sink_regs.sv
module tb_trace_sink_regs;
    localparam int unsigned LAT = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        drain_empty = 1'b1;
    logic        active_o, enable_o, clk_center_o, calibrate_o;
    logic [3:0]  mode_o;
    logic [2:0]  sync_freq_o;
    logic [15:0] divider_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // bench model of the stored state
    logic        m_act, m_en, m_cc, m_cal;
    logic [3:0]  m_mode;
    logic [2:0]  m_sync;
    logic [15:0] m_div;

    trace_sink_regs #(.ADDR_W(12), .PWR_LAT(LAT), .DIV_RESET(16'h000F)) dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .drain_empty(drain_empty), .active_o(active_o),
        .enable_o(enable_o), .mode_o(mode_o), .clk_center_o(clk_center_o),
        .calibrate_o(calibrate_o), .sync_freq_o(sync_freq_o),
        .divider_o(divider_o));

    always #4 clk = ~clk;

    function automatic bit legal_code(input logic [3:0] c);
        return c == 0 || c == 4 || c == 5 || (c >= 8 && c <= 12);
    endfunction

    function automatic logic [31:0] exp_ctrl();
        if (!m_act) return 32'h0000_0008;
        return {m_div, 1'b0, m_sync, 2'b00, m_cal, m_cc, m_mode,
                drain_empty, 1'b0, m_en, 1'b1};
    endfunction

    task automatic model_write(input logic [31:0] d);
        if (legal_code(d[7:4])) m_mode = d[7:4];
        m_cc   = d[8] && (m_mode >= 8) && (m_mode <= 12);
        m_en   = d[1];
        m_cal  = d[9];
        m_sync = d[14:12];
        m_div  = d[31:16];
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // called at a negedge; the write lands on the next posedge
    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check_outputs(input string tag);
        check(tag, {26'd0, enable_o, mode_o, clk_center_o},
                   {26'd0, m_en & m_act, m_mode, m_cc});
        check(tag, {12'd0, calibrate_o, sync_freq_o, divider_o},
                   {12'd0, m_cal, m_sync, m_div});
        check(tag, {31'd0, active_o}, {31'd0, m_act});
    endtask

    initial begin
        #(8 * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [31:0] d;
        void'($urandom(32'd20240611));
        m_act = 0; m_en = 0; m_cc = 0; m_cal = 0; m_mode = 0; m_sync = 0; m_div = 16'h000F;

        idle(3);
        rst = 1'b0;
        idle(1);

        // R1 reset state
        rd(12'h000, v); check("R1 ctrl reset", v, 32'h0000_0008);
        check_outputs("R1 outputs reset");
        rd(12'h004, v); check("R3 impl while off", v, 32'h0);

        // R3 field writes ignored while off
        wr(12'h000, 32'hFFFF_F3B2);
        rd(12'h000, v); check("R3 ctrl after off write", v, 32'h0000_0008);
        check_outputs("R3 outputs after off write");

        // R2 power-up with a coincident field write on the completion edge
        wr(12'h000, 32'h0000_0001);
        idle(LAT - 1);
        rd(12'h000, v); check("R2 active not early", {31'd0, v[0]}, 32'd0);
        wr(12'h000, 32'h1234_5983);
        m_act = 1;
        rd(12'h000, v); check("R3 coincident write dropped", v, exp_ctrl());
        check("R2 active after latency", {31'd0, active_o}, 32'd1);

        // R7 identification
        rd(12'h004, v); check("R7 impl value", v, 32'h0000_0A01);

        // R4 R5 directed mode handling
        d = 32'h0000_0193; wr(12'h000, d); model_write(d);
        rd(12'h000, v); check("R5 parallel center set", v, exp_ctrl());
        d = 32'h0000_0133; wr(12'h000, d); model_write(d);
        rd(12'h000, v); check("R4 illegal code 3 kept", v, exp_ctrl());
        d = 32'h0000_0143; wr(12'h000, d); model_write(d);
        rd(12'h000, v); check("R5 center cleared in serial", v, exp_ctrl());
        d = 32'h0000_01F1; wr(12'h000, d); model_write(d);
        rd(12'h000, v); check("R4 illegal code 15 kept", v, exp_ctrl());
        d = 32'h0000_01C1; wr(12'h000, d); model_write(d);
        rd(12'h000, v); check("R5 mode and center same write", v, exp_ctrl());

        // R6 full layout with reserved bits set in the write
        d = 32'hABCD_FFFF; wr(12'h000, d); model_write(d);
        rd(12'h000, v); check("R6 layout and reserved", v, exp_ctrl());
        check_outputs("R8 outputs follow fields");

        // R9 empty input
        drain_empty = 1'b0;
        rd(12'h000, v); check("R9 empty low", {31'd0, v[3]}, 32'd0);
        drain_empty = 1'b1;
        rd(12'h000, v); check("R9 empty high", {31'd0, v[3]}, 32'd1);

        // R10 unmapped addresses
        rd(12'h008, v); check("R10 unmapped read", v, 32'h0);
        wr(12'h008, 32'h0000_0000);
        wr(12'h010, 32'h0000_0040);
        rd(12'h000, v); check("R10 unmapped write no effect", v, exp_ctrl());

        // random writes while powered
        for (int i = 0; i < 300; i++) begin
            d = $urandom;
            d[0] = 1'b1;
            drain_empty = 1'($urandom);
            if (($urandom % 8) == 0) begin
                wr(12'h000 + 12'(($urandom % 4) * 4 + 8), d);
            end else begin
                wr(12'h000, d); model_write(d);
            end
            rd(12'h000, v); check("R4 R5 R6 random write", v, exp_ctrl());
            check_outputs("R8 random outputs");
        end

        // R2 power-down
        drain_empty = 1'b1;
        wr(12'h000, {m_div, 1'b0, m_sync, 2'b00, m_cal, m_cc, m_mode, 4'b0010});
        idle(LAT - 1);
        check("R2 still powered", {31'd0, active_o}, 32'd1);
        idle(1);
        m_act = 0;
        rd(12'h000, v); check("R3 ctrl after power-down", v, 32'h0000_0008);
        check_outputs("R8 outputs after power-down");
        rd(12'h004, v); check("R3 impl after power-down", v, 32'h0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule